// File: doc/BRIEF.md
# Entropy Sampling and Debiasing Pipeline

This block turns sixteen free-running, asynchronous entropy lines into a stream of debiased random bits. Each line first crosses into the clock domain through two flip-flops. A sampler then captures all sixteen lines together once every N enabled clock cycles. A folding stage XORs M consecutive samples of each line into one bit, so every M sample events yield a sixteen-bit word.

A two-state serializer feeds that word, one bit pair per cycle, into a Von Neumann corrector. The corrected bits collect in a sixteen-entry buffer and leave on a valid/ready port. Software sets N and M while the generator is stopped. Raising `enable` starts sampling. Lowering it stops sampling, and the later stages go on draining what they already hold.

The serializer has two states. In SER_IDLE it waits for a folded word and moves to SER_DRAIN when one arrives. In SER_DRAIN it passes one pair per cycle. After the last pair it returns to SER_IDLE, or stays in SER_DRAIN if a new word arrives in that same cycle.

Top module: `entropy_debias_pipe`

## Requirements
- R1: Each sample event captures all sixteen entropy lines as they stood at the clock edge two edges before the edge on which the event occurs.
- R2: While `enable` is high, a sample event occurs on every N-th enabled edge, the first on the N-th edge after `enable` rises. The interval counter clears on any edge where `enable` is low.
- R3: After every M sample events, a folded word is formed. Its bit i is the XOR of the M samples of line i.
- R4: A folded word is split into pairs (bit 2j first, bit 2j+1 second) and taken in ascending j, so line 0 goes first. A pair with equal bits yields nothing. First 0 then 1 yields output 0, and first 1 then 0 yields output 1.
- R5: `cfg_interval` and `cfg_fold` are loaded only on edges where `enable` is low. Changes made while `enable` is high do not affect the output stream.
- R6: An interval of 0 is used as 1. A fold size of 0 is used as 1, and a fold size above 8 is used as 8.
- R7: Corrected bits leave in order. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` holds its value.
- R8: The output buffer holds 16 bits. A corrected bit that arrives while the buffer is full and not being read is dropped, and the bits already held are kept. The drop sets `overflow`, which stays set until reset.
- R9: The serializer needs eight cycles per word. A folded word that arrives while the previous word still has more than its final pair to pass is discarded, and `overflow` is set. With N×M ≥ 8, no words are lost.
- R10: A synchronous active-high `rst` clears the interval counter, fold accumulators, serializer, buffer and `overflow`. On the cycle after reset, `out_valid` and `overflow` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Sampling runs while high; configuration loads while low |
| cfg_interval | input | 8 | Sampling interval N |
| cfg_fold | input | 4 | Fold group size M |
| ent_in | input | 16 | Asynchronous entropy lines, line 0 in bit 0 |
| out_ready | input | 1 | Consumer accepts a bit |
| out_valid | output | 1 | A corrected bit is available |
| out_bit | output | 1 | Corrected random bit |
| overflow | output | 1 | Sticky flag for a dropped word or bit |

## Verification
The assertions assume that `rst` is held for at least one edge before the first use. They also assume that `cfg_interval` and `cfg_fold` are only meaningful as loaded values, so they check the registered copies rather than the inputs.

The entropy lines change only just after a clock edge. The bench model can therefore read the exact value each synchronizer stage captured, and compare every output bit with a prediction built from the same interval, fold and pairing rules. The loss-free tables keep N×M at 8 or more and hold `out_ready` high. Two separate directed runs break those limits on purpose to provoke both drop paths.

// File: rtl/edp_pkg.sv
`timescale 1ns/1ps
package edp_pkg;
    localparam int SRC_COUNT  = 16;
    localparam int N_W        = 8;
    localparam int M_MAX      = 8;
    localparam int M_W        = 4;
    localparam int FIFO_DEPTH = 16;

    typedef enum logic [0:0] {
        SER_IDLE,
        SER_DRAIN
    } ser_state_t;
endpackage

// File: rtl/edp_sync_bank.sv
`timescale 1ns/1ps
module edp_sync_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [1:0] stage_q;
        always_ff @(posedge clk) begin
            stage_q <= {stage_q[0], async_in[g]};
        end
        assign sync_out[g] = stage_q[1];
    end
endmodule

// File: rtl/edp_sampler.sv
`timescale 1ns/1ps
module edp_sampler #(
    parameter int W   = 16,
    parameter int N_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enable,
    input  logic [N_W-1:0] interval,
    input  logic [W-1:0]   lines,
    output logic           samp_vld,
    output logic [W-1:0]   samp_vec
);
    logic [N_W-1:0] tick_cnt;
    logic           at_end;

    assign at_end = (tick_cnt == interval - N_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            samp_vld <= 1'b0;
            samp_vec <= '0;
        end else begin
            samp_vld <= 1'b0;
            if (!enable) begin
                tick_cnt <= '0;
            end else if (at_end) begin
                tick_cnt <= '0;
                samp_vld <= 1'b1;
                samp_vec <= lines;
            end else begin
                tick_cnt <= tick_cnt + N_W'(1);
            end
        end
    end
endmodule

// File: rtl/edp_folder.sv
`timescale 1ns/1ps
module edp_folder #(
    parameter int W   = 16,
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           samp_vld,
    input  logic [W-1:0]   samp_vec,
    input  logic [M_W-1:0] group,
    output logic           word_vld,
    output logic [W-1:0]   word
);
    logic [W-1:0]   acc_q;
    logic [M_W-1:0] seen_q;
    logic           closes;

    assign closes = ((M_W+1)'(seen_q) + (M_W+1)'(1)) >= (M_W+1)'(group);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            seen_q   <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (samp_vld) begin
                if (closes) begin
                    word     <= acc_q ^ samp_vec;
                    word_vld <= 1'b1;
                    acc_q    <= '0;
                    seen_q   <= '0;
                end else begin
                    acc_q  <= acc_q ^ samp_vec;
                    seen_q <= seen_q + M_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/edp_vn_serializer.sv
`timescale 1ns/1ps
module edp_vn_serializer
    import edp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         word_vld,
    input  logic [W-1:0] word,
    output logic         bit_vld,
    output logic         bit_val,
    output logic         word_lost
);
    localparam int PAIRS = W / 2;
    localparam int PW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [PW-1:0] LAST = PW'(PAIRS - 1);

    ser_state_t     state_q, state_d;
    logic [W-1:0]   word_q;
    logic [PW-1:0]  idx_q;
    logic           accept;
    logic [W-1:0]   shifted;

    assign accept = word_vld && ((state_q == SER_IDLE) || (idx_q == LAST));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE:  if (accept) state_d = SER_DRAIN;
            SER_DRAIN: if (idx_q == LAST && !accept) state_d = SER_IDLE;
            default:   state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SER_IDLE;
            idx_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                word_q <= word;
                idx_q  <= '0;
            end else if (state_q == SER_DRAIN) begin
                idx_q <= idx_q + PW'(1);
            end
        end
    end

    assign shifted = word_q >> {idx_q, 1'b0};

    always_comb begin
        bit_vld   = 1'b0;
        bit_val   = shifted[0];
        word_lost = word_vld && !accept;
        unique case (state_q)
            SER_IDLE:  bit_vld = 1'b0;
            SER_DRAIN: bit_vld = shifted[0] ^ shifted[1];
            default:   bit_vld = 1'b0;
        endcase
    end
endmodule

// File: rtl/edp_bit_fifo.sv
`timescale 1ns/1ps
module edp_bit_fifo #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic din,
    input  logic rd_ready,
    output logic rd_valid,
    output logic dout,
    output logic dropped
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0] mem_q;
    logic [AW-1:0]    wp_q, rp_q;
    logic [AW:0]      cnt_q;
    logic             pop, push_ok;

    assign rd_valid = (cnt_q != '0);
    assign dout     = mem_q[rp_q];
    assign pop      = rd_valid && rd_ready;
    assign push_ok  = push && ((cnt_q != (AW+1)'(DEPTH)) || pop);
    assign dropped  = push && !push_ok;

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + AW'(1);
            if (pop)     rp_q <= rp_q + AW'(1);
            cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop);
        end
    end
endmodule

// File: rtl/entropy_debias_pipe.sv
`timescale 1ns/1ps
module entropy_debias_pipe
    import edp_pkg::*;
#(
    parameter int SRCS  = SRC_COUNT,
    parameter int NW    = N_W,
    parameter int MW    = M_W,
    parameter int MMAX  = M_MAX,
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic [NW-1:0]   cfg_interval,
    input  logic [MW-1:0]   cfg_fold,
    input  logic [SRCS-1:0] ent_in,
    input  logic            out_ready,
    output logic            out_valid,
    output logic            out_bit,
    output logic            overflow
);
    logic [NW-1:0]   n_q, n_clamped;
    logic [MW-1:0]   m_q, m_clamped;
    logic [SRCS-1:0] lines_sync, samp_vec, word;
    logic            samp_vld, word_vld, bit_vld, bit_val;
    logic            word_lost, bit_dropped;

    always_comb begin
        n_clamped = (cfg_interval == '0) ? NW'(1) : cfg_interval;
        if (cfg_fold == '0)             m_clamped = MW'(1);
        else if (cfg_fold > MW'(MMAX))  m_clamped = MW'(MMAX);
        else                            m_clamped = cfg_fold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q <= NW'(1);
            m_q <= MW'(1);
        end else if (!enable) begin
            n_q <= n_clamped;
            m_q <= m_clamped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                           overflow <= 1'b0;
        else if (word_lost || bit_dropped) overflow <= 1'b1;
    end

    edp_sync_bank #(.W(SRCS)) u_sync (
        .clk(clk), .async_in(ent_in), .sync_out(lines_sync)
    );

    edp_sampler #(.W(SRCS), .N_W(NW)) u_sampler (
        .clk(clk), .rst(rst), .enable(enable), .interval(n_q),
        .lines(lines_sync), .samp_vld(samp_vld), .samp_vec(samp_vec)
    );

    edp_folder #(.W(SRCS), .M_W(MW)) u_folder (
        .clk(clk), .rst(rst), .samp_vld(samp_vld), .samp_vec(samp_vec),
        .group(m_q), .word_vld(word_vld), .word(word)
    );

    edp_vn_serializer #(.W(SRCS)) u_vn (
        .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
        .bit_vld(bit_vld), .bit_val(bit_val), .word_lost(word_lost)
    );

    edp_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(bit_vld), .din(bit_val),
        .rd_ready(out_ready), .rd_valid(out_valid), .dout(out_bit),
        .dropped(bit_dropped)
    );
endmodule

// File: rtl/edp_checker.sv
`timescale 1ns/1ps
module edp_checker #(
    parameter int NW = 8,
    parameter int MW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          enable,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_bit,
    input logic          overflow,
    input logic          samp_vld,
    input logic [NW-1:0] n_q,
    input logic [MW-1:0] m_q
);
    logic rst_seen = 1'b0;
    always @(posedge clk) rst_seen <= rst;

    always @(negedge clk) begin
        if (rst_seen) begin
            a_r10_reset_clears: assert (!out_valid && !overflow);
        end
    end

    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

    a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        enable |=> ($stable(n_q) && $stable(m_q)));

    a_r2_sample_gap: assert property (@(posedge clk) disable iff (rst)
        (samp_vld && n_q > NW'(1)) |=> !samp_vld);
endmodule

bind entropy_debias_pipe edp_checker #(.NW(NW), .MW(MW)) u_edp_checker (
    .clk(clk), .rst(rst), .enable(enable), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .overflow(overflow),
    .samp_vld(samp_vld), .n_q(n_q), .m_q(m_q)
);

// File: tb/entropy_debias_pipe_test.sv
`timescale 1ns/1ps
module entropy_debias_pipe_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [7:0]  cfg_interval = 8'd7;
    logic [3:0]  cfg_fold = 4'd3;
    logic [15:0] ent_in = 16'h0;
    logic        out_ready = 1'b1;
    logic        out_valid, out_bit, overflow;

    always #2 clk = ~clk;

    entropy_debias_pipe uut (
        .clk(clk), .rst(rst), .enable(enable), .cfg_interval(cfg_interval),
        .cfg_fold(cfg_fold), .ent_in(ent_in), .out_ready(out_ready),
        .out_valid(out_valid), .out_bit(out_bit), .overflow(overflow)
    );

    int checks = 0, fails = 0, got = 0;
    bit chk_on = 1'b1;
    int exp_q[$];
    logic [31:0] rng = 32'h1234_5678;

    // entropy lines change 1 ns after each edge
    always @(posedge clk) begin
        #1;
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        ent_in <= rng[15:0];
    end

    // reference model built from R1..R6 and R9
    int m_n = 1, m_m = 1, m_cnt = 0, m_fcnt = 0;
    logic [15:0] m_acc = '0, hist_a = '0, hist_b = '0;
    always @(posedge clk) begin : model
        logic [15:0] w;
        if (rst) begin
            m_cnt = 0; m_fcnt = 0; m_acc = '0;
        end else if (!enable) begin
            m_n = (cfg_interval == 0) ? 1 : int'(cfg_interval);
            m_m = (cfg_fold == 0) ? 1 : ((cfg_fold > 4'd8) ? 8 : int'(cfg_fold));
            m_cnt = 0;
        end else if (m_cnt == m_n - 1) begin
            m_cnt = 0;
            m_acc = m_acc ^ hist_b;
            if (m_fcnt + 1 >= m_m) begin
                w = m_acc; m_acc = '0; m_fcnt = 0;
                for (int j = 0; j < 8; j++)
                    if (w[2*j] != w[2*j+1]) exp_q.push_back(int'(w[2*j]));
            end else begin
                m_fcnt++;
            end
        end else begin
            m_cnt++;
        end
        hist_b = hist_a;
        hist_a = ent_in;
    end

    // per-bit comparison at the handshake: R1 R2 R3 R4 R7
    always @(negedge clk) begin
        if (chk_on && out_valid && out_ready) begin
            int e;
            got++;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected bit actual=%0d expected=none", out_bit);
            end else begin
                e = exp_q.pop_front();
                if (out_bit !== e[0]) begin
                    fails++;
                    $display("FAIL R1 R2 R3 R4 bit %0d actual=%0d expected=%0d", got, out_bit, e);
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; enable = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    localparam int ROWS = 5;
    localparam int N_TAB [ROWS] = '{7, 1, 0, 20, 13};
    localparam int M_TAB [ROWS] = '{3, 8, 12, 0, 5};
    localparam int C_TAB [ROWS] = '{700, 400, 400, 600, 900};

    initial begin : wd
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic held;
        tick(4);
        rst = 1'b0;
        @(negedge clk);
        check("R10 out_valid after reset", out_valid, 0);
        check("R10 overflow after reset", overflow, 0);
        tick(1);

        for (int r = 0; r < ROWS; r++) begin
            do_reset();
            cfg_interval = 8'(N_TAB[r]);
            cfg_fold = 4'(M_TAB[r]);
            out_ready = 1'b1;
            got = 0;
            tick(4);
            enable = 1'b1;
            tick(C_TAB[r] / 2);
            cfg_interval = 8'd2;   // R5: ignored while enabled
            cfg_fold = 4'd1;
            tick(C_TAB[r] / 2);
            enable = 1'b0;
            tick(150);
            @(negedge clk);
            check("R4 R5 R6 all predicted bits delivered", exp_q.size(), 0);
            check("R6 R9 no loss at N*M>=8", overflow, 0);
            check("R7 bits observed", int'(got > 0), 1);
            tick(1);
        end

        // R8: full buffer drops newest bits, keeps the first sixteen
        do_reset();
        cfg_interval = 8'd7; cfg_fold = 4'd3; out_ready = 1'b0;
        tick(4);
        enable = 1'b1;
        tick(600);
        enable = 1'b0;
        tick(60);
        @(negedge clk);
        check("R8 overflow set when full", overflow, 1);
        check("R8 more bits produced than held", int'(exp_q.size() > 16), 1);
        held = out_bit;
        tick(3);
        @(negedge clk);
        check("R7 out_valid held while stalled", out_valid, 1);
        check("R7 out_bit stable while stalled", out_bit, held);
        tick(1);
        got = 0;
        out_ready = 1'b1;
        tick(40);
        @(negedge clk);
        check("R8 exactly sixteen bits kept", got, 16);
        check("R8 buffer empty after drain", out_valid, 0);
        exp_q.delete();
        tick(1);

        // R9: words faster than the serializer are lost
        chk_on = 1'b0;
        do_reset();
        cfg_interval = 8'd1; cfg_fold = 4'd1;
        tick(4);
        enable = 1'b1;
        tick(40);
        enable = 1'b0;
        tick(30);
        @(negedge clk);
        check("R9 overflow on serializer overrun", overflow, 1);
        tick(1);
        do_reset();
        @(negedge clk);
        check("R10 reset clears overflow", overflow, 0);
        check("R10 reset empties buffer", out_valid, 0);
        exp_q.delete();
        chk_on = 1'b1;
        tick(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule